// File: doc/BRIEF.md
# Bit-Parallel Life Generation Engine

This block computes one generation of Conway's Game of Life for a grid that is 16 cells wide and up to 64 rows tall. Each row of the grid is held as one 16-bit word, with one bit per column. A row's next state is found for all 16 columns at once. The logic forms vertical half-adder and full-adder partial sums of the rows above, at and below the current row. Single-position shifts then combine the sums of neighbouring columns. The result is a two-bit neighbour sum plus an inhibit flag that marks four or more live neighbours, so no per-cell four-bit counter is built.

A small sequencer streams the grid through a three-row window. The host pulses `start` with a row count. The block then reads the input row array through a combinational read port, one row per cycle. It writes each next-state row to a separate output array through a write port, one row per cycle, in ascending row order. When the last row has been written, the block raises `done`. Rows above the first and below the last are treated as dead, and so are columns to the left of bit 0 and to the right of bit 15.

Top module: `lifeGenTop`

## Requirements
- R1: While reset is held and after it is released, `done` and `wrEn` are 0 until a run is started.
- R2: For every cell, the written value is 1 when the cell is live (bit = 1) and has 2 or 3 live neighbours among its 8 orthogonal and diagonal neighbours. It is also 1 when the cell is dead (bit = 0) and has exactly 3 live neighbours. It is 0 in every other case.
- R3: Cells outside the grid count as dead. These are rows below index 0 or at index R and above, columns below bit 0, and columns above bit 15.
- R4: A cell with 4 or more live neighbours is written as 0, whatever its current state.
- R5: After an accepted `start`, the next-state row k is written to `wrAddr` = k. The writes come in consecutive cycles, in ascending order, and the first write goes to address 0.
- R6: A run of R rows makes exactly R writes, one to each address 0 to R-1. Results go only to the output array, so every input row is read unmodified.
- R7: `done` rises in the cycle after the last write and stays high, with no further writes, until the next `start`.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The run continues with its original row count.
- R9: A `rowCount` of 0 runs one row. A `rowCount` above 64 runs 64 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a generation |
| rowCount | input | 7 | Number of grid rows R, sampled at start |
| rdAddr | output | 6 | Row index on the input-array read port |
| rdData | input | 16 | Input row word at rdAddr, returned combinationally |
| wrEn | output | 1 | Write strobe for the output array |
| wrAddr | output | 6 | Output row index |
| wrData | output | 16 | Next-state row word |
| done | output | 1 | Generation complete; held until the next start |

## Verification
On every cycle, the assertions check the write ordering of the output port: the first write goes to row 0 and each following write goes to the next address. They also check that `done` follows a write, holds until `start`, and never overlaps a write. The correctness of each next-state word can only be shown by the bench scenarios. These compare every written row against a neighbour-counting model over random grids, blinker and glider shapes, a fully live grid and edge-hugging patterns. The count clamping and the ignoring of a `start` during a run are also shown only by scenarios.

// File: rtl/lifePkg.sv
package lifePkg;
  typedef struct packed {
    logic clearWin;   // zero the three-row window
    logic shiftWin;   // advance the window by one row
    logic feedZero;   // shift in a dead row instead of rdData
  } winCtrl_t;
endpackage

// File: rtl/lifeRowLogic.sv
module lifeRowLogic #(
  parameter int W = 16
) (
  input  logic [W-1:0] north,
  input  logic [W-1:0] centre,
  input  logic [W-1:0] south,
  output logic [W-1:0] nextRow
);
  logic [W-1:0] pairLo, pairHi, tripLo, tripHi;
  logic [W-1:0] tripLoL, tripLoR, tripHiL, tripHiR;
  logic [W-1:0] cnt0, cnt0Carry, cnt1, inhibit;

  always_comb begin
    // vertical pair of north and south: half adder
    pairLo = north ^ south;
    pairHi = north & south;
    // vertical triple including the centre: full adder
    tripLo = pairLo ^ centre;
    tripHi = ((north | south) & centre) | pairHi;
    // neighbouring columns; zero enters at the edges
    tripLoL = tripLo << 1;
    tripLoR = tripLo >> 1;
    tripHiL = tripHi << 1;
    tripHiR = tripHi >> 1;
    // weight-1 terms
    cnt0      = tripLoL ^ pairLo ^ tripLoR;
    cnt0Carry = (tripLoL & pairLo) | (tripLoR & (tripLoL | pairLo));
    // weight-2 terms: four inputs, keep parity and flag two or more
    cnt1    = cnt0Carry ^ pairHi ^ tripHiL ^ tripHiR;
    inhibit = (tripHiL & pairHi) | (tripHiR & cnt0Carry)
            | ((tripHiL ^ pairHi) & (tripHiR ^ cnt0Carry));
    nextRow = cnt1 & (cnt0 | centre) & ~inhibit;
  end
endmodule

// File: rtl/lifeDatapath.sv
module lifeDatapath
  import lifePkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  winCtrl_t     winCtrl,
  input  logic [W-1:0] rdData,
  output logic [W-1:0] nextRow
);
  logic [W-1:0] rowAbove, rowMid, rowBelow;

  always_ff @(posedge clk) begin
    if (!rstN || winCtrl.clearWin) begin
      rowAbove <= '0;
      rowMid   <= '0;
      rowBelow <= '0;
    end else if (winCtrl.shiftWin) begin
      rowAbove <= rowMid;
      rowMid   <= rowBelow;
      rowBelow <= winCtrl.feedZero ? '0 : rdData;
    end
  end

  lifeRowLogic #(.W(W)) row_i (
    .north  (rowAbove),
    .centre (rowMid),
    .south  (rowBelow),
    .nextRow(nextRow)
  );
endmodule

// File: rtl/lifeCtrl.sv
module lifeCtrl
  import lifePkg::*;
#(
  parameter int MAX_ROWS = 64,
  parameter int ADDR_W   = $clog2(MAX_ROWS),
  parameter int CNT_W    = $clog2(MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  rowCount,
  output winCtrl_t          winCtrl,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outRow,
  output logic              done
);
  typedef enum logic {IDLE, RUN} state_t;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ROWS);

  state_t           state;
  logic [CNT_W-1:0] step, rowsLat, rowsClamped;
  logic             accept, lastStep;

  always_comb begin
    if (rowCount == '0)          rowsClamped = CNT_W'(1);
    else if (rowCount > MAX_CNT) rowsClamped = MAX_CNT;
    else                         rowsClamped = rowCount;
    accept   = start && (state == IDLE);
    lastStep = (step == rowsLat);
    winCtrl.clearWin = accept;
    winCtrl.shiftWin = (state == RUN);
    winCtrl.feedZero = lastStep;
    rdAddr = step[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      step     <= '0;
      rowsLat  <= CNT_W'(1);
      outValid <= 1'b0;
      outRow   <= '0;
      done     <= 1'b0;
    end else begin
      outValid <= (state == RUN) && (step != '0);
      outRow   <= ADDR_W'(step - 1'b1);
      if (accept) begin
        state   <= RUN;
        step    <= '0;
        rowsLat <= rowsClamped;
        done    <= 1'b0;
      end else begin
        if (state == RUN) begin
          step <= step + 1'b1;
          if (lastStep) state <= IDLE;
        end
        if (outValid && (outRow == ADDR_W'(rowsLat - 1'b1))) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lifeGenTop.sv
module lifeGenTop
  import lifePkg::*;
#(
  parameter int W        = 16,
  parameter int MAX_ROWS = 64
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [$clog2(MAX_ROWS + 1)-1:0]  rowCount,
  output logic [$clog2(MAX_ROWS)-1:0]      rdAddr,
  input  logic [W-1:0]                     rdData,
  output logic                             wrEn,
  output logic [$clog2(MAX_ROWS)-1:0]      wrAddr,
  output logic [W-1:0]                     wrData,
  output logic                             done
);
  localparam int ADDR_W = $clog2(MAX_ROWS);
  localparam int CNT_W  = $clog2(MAX_ROWS + 1);

  winCtrl_t winCtrl;

  lifeCtrl #(.MAX_ROWS(MAX_ROWS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rowCount(rowCount),
    .winCtrl (winCtrl),
    .rdAddr  (rdAddr),
    .outValid(wrEn),
    .outRow  (wrAddr),
    .done    (done)
  );

  lifeDatapath #(.W(W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .winCtrl(winCtrl),
    .rdData (rdData),
    .nextRow(wrData)
  );
endmodule

// File: rtl/lifeGenChk.sv
module lifeGenChk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done
);
  // R5
  first_write_row0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrEn) |-> (wrAddr == '0));
  // R5
  write_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));
  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(wrEn));
  // R7
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

bind lifeGenTop lifeGenChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .wrEn  (wrEn),
  .wrAddr(wrAddr),
  .done  (done)
);

// File: tb/lifeGenTop_tb_top.sv
module lifeGenTop_tb_top;
  localparam int W = 16;
  localparam int MAXR = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [6:0]    rowCount = '0;
  logic [5:0]    rdAddr, wrAddr;
  logic [W-1:0]  rdData, wrData;
  logic          wrEn, done;

  logic [W-1:0]  inMem  [MAXR];
  logic [W-1:0]  outMem [MAXR];
  logic [W-1:0]  expRow [MAXR];
  int            writes = 0;
  int            checks = 0;
  int            fails  = 0;
  int            cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign rdData = inMem[rdAddr];

  lifeGenTop dut_i (
    .clk(clk), .rstN(rstN), .start(start), .rowCount(rowCount),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (wrEn) begin
      outMem[wrAddr] <= wrData;
      writes <= writes + 1;
    end
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit cellAt(input int r, input int c, input int rows);
    if (r < 0 || r >= rows || c < 0 || c >= W) return 1'b0;
    return inMem[r][c];
  endfunction

  // Reference: per-cell neighbour count
  task automatic buildExpected(input int rows);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < W; c++) begin
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (dr != 0 || dc != 0) n += int'(cellAt(r + dr, c + dc, rows));
        if (inMem[r][c]) expRow[r][c] = (n == 2 || n == 3);
        else             expRow[r][c] = (n == 3);
      end
    end
  endtask

  task automatic runGrid(input int reqRows, input int effRows, input string req,
                         input bit pokeStart);
    int waitCyc = 0;
    for (int i = 0; i < MAXR; i++) outMem[i] = 16'hDEAD;
    buildExpected(effRows);
    @(negedge clk);
    writes = 0;
    rowCount = 7'(reqRows);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeStart) begin
      @(negedge clk);
      rowCount = 7'd2;
      start = 1'b1;          // R8: should be ignored mid-run
      @(negedge clk);
      start = 1'b0;
      rowCount = 7'(reqRows);
    end
    while (!done && waitCyc < 400) begin
      @(negedge clk);
      waitCyc++;
    end
    check(done == 1'b1, "R7 done raised", int'(done), 1);
    check(writes == effRows, {req, " R6 write count"}, writes, effRows);
    for (int r = 0; r < effRows; r++)
      check(outMem[r] == expRow[r], {req, " R2 row"}, int'(outMem[r]), int'(expRow[r]));
    for (int r = 0; r < effRows; r++)
      if (outMem[r] != expRow[r]) $display("  row %0d mismatch", r);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && writes == effRows, "R7 done held, no extra writes",
          writes, effRows);
  endtask

  task automatic clearGrid();
    for (int i = 0; i < MAXR; i++) inMem[i] = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clearGrid();
    repeat (3) @(negedge clk);
    check(done == 1'b0 && wrEn == 1'b0, "R1 reset state", {30'd0, done, wrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && wrEn == 1'b0, "R1 idle after reset", {30'd0, done, wrEn}, 0);

    // blinker, vertical at column 5
    clearGrid();
    inMem[2] = 16'h0020; inMem[3] = 16'h0020; inMem[4] = 16'h0020;
    runGrid(8, 8, "blinker", 1'b0);
    check(outMem[3] == 16'h0070, "R2 blinker turns horizontal", int'(outMem[3]), 16'h0070);

    // glider
    clearGrid();
    inMem[1] = 16'h0004; inMem[2] = 16'h0008; inMem[3] = 16'h000E;
    runGrid(10, 10, "glider", 1'b0);

    // R3: patterns hugging columns 0/15 and rows 0/R-1
    clearGrid();
    inMem[0] = 16'h8001; inMem[1] = 16'h8001; inMem[2] = 16'h8001;
    inMem[3] = 16'hC003; inMem[4] = 16'hC003;
    runGrid(5, 5, "R3 edges", 1'b0);
    check(outMem[0] == 16'h0000, "R3 top edge row", int'(outMem[0]), 16'h0000);

    // R4: fully live grid, interior cells have 8 neighbours
    clearGrid();
    for (int i = 0; i < 6; i++) inMem[i] = 16'hFFFF;
    runGrid(6, 6, "R4 full", 1'b0);
    check(outMem[2] == 16'h0000, "R4 inhibit interior", int'(outMem[2]), 16'h0000);

    // R9: zero count runs one row; single-row birth impossible, survivors checked
    clearGrid();
    inMem[0] = 16'h0E00; inMem[1] = 16'hFFFF;
    runGrid(0, 1, "R9 zero count", 1'b0);
    check(outMem[1] == 16'hDEAD, "R9 row 1 untouched", int'(outMem[1]), 16'hDEAD);

    // random grids, including max size and clamped oversize
    for (int t = 0; t < 6; t++) begin
      int rows = 1 + int'($urandom % 64);
      for (int i = 0; i < MAXR; i++) inMem[i] = 16'($urandom);
      runGrid(rows, rows, "random", 1'b0);
    end
    for (int i = 0; i < MAXR; i++) inMem[i] = 16'($urandom);
    runGrid(64, 64, "random max", 1'b0);
    for (int i = 0; i < MAXR; i++) inMem[i] = 16'($urandom);
    runGrid(100, 64, "R9 oversize clamp", 1'b0);

    // R8: start while busy is ignored
    for (int i = 0; i < MAXR; i++) inMem[i] = 16'($urandom);
    runGrid(20, 20, "R8 start while busy", 1'b1);

    // R6: input array unchanged (separate buffer), reran on same input
    for (int i = 0; i < MAXR; i++) inMem[i] = 16'($urandom);
    runGrid(12, 12, "R6 rerun A", 1'b0);
    runGrid(12, 12, "R6 rerun B", 1'b0);

    // R5: first write goes to address 0 in ascending order
    clearGrid();
    inMem[0] = 16'h0007;
    @(negedge clk);
    rowCount = 7'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!wrEn) @(negedge clk);
    check(wrAddr == 6'd0, "R5 first write address", int'(wrAddr), 0);
    @(negedge clk);
    check(wrEn && wrAddr == 6'd1, "R5 second write address", int'(wrAddr), 1);
    @(negedge clk);
    check(wrEn && wrAddr == 6'd2, "R5 third write address", int'(wrAddr), 2);
    @(negedge clk);
    check(done == 1'b1, "R7 done after last write", int'(done), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule